// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This block is a byte-addressed timer/counter for a small controller subsystem. Each clock of `clk` is one instruction cycle. In timer mode the count advances on instruction cycles. In counter mode it advances on edges of an external pin, which is first brought into the clock domain by a synchronizer. An optional power-of-two prescaler can sit in front of the count. The count wraps as either an 8-bit or a 16-bit value, and each wrap raises a sticky interrupt flag.

Software sees four byte registers: control, count low byte, high-byte buffer and flag. The true upper byte of the count is never accessed directly, so that a byte-wide bus can move all 16 bits consistently. Reading the low byte copies the upper byte into the buffer. Writing the low byte loads the buffer into the upper byte in the same edge. Any write to the low byte also holds the count for the next two cycles.

Top module: `buffered_timer16`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: With control bit 7 set, timer mode (bit 5 = 0) and bit 3 = 1 (prescaler bypassed), the count advances by one every cycle. With bit 7 clear the count holds.
- R3: With bit 3 = 0, the count advances once per 2^(s+1) qualifying cycles, where s is control bits 2:0. A write to the low byte or to the buffer resets the prescaler and produces no increment in that cycle.
- R4: A write to address 1 loads the count with {buffer, written byte} at that edge. A write to address 2 changes only the buffer and leaves the count as it was.
- R5: A read of address 1 returns the current low byte and at the same edge copies the true upper byte into the buffer (address 2).
- R6: After a write to address 1, the count does not change at the next two edges. It can first change at the third edge.
- R7: With control bit 6 = 1 (8-bit width), only the low byte counts, the upper byte holds, and the flag sets on a wrap of the low byte from 0xFF to 0x00.
- R8: With bit 6 = 0 (16-bit width), a carry from low to high sets no flag. The flag sets on a wrap from 0xFFFF to 0x0000.
- R9: The flag (address 3, bit 0, mirrored on `irq`) stays set until a write to address 3 with bit 0 = 0. A write with bit 0 = 1 leaves it set.
- R10: In counter mode (bit 5 = 1), bit 4 = 0 counts rising pin edges and bit 4 = 1 counts falling pin edges. The other edge has no effect.
- R11: A pin change set up before clock edge P1 shows in the count after edge P3, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 control, 1 low byte, 2 buffer, 3 flag |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; on address 1 it latches the upper byte |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Selected register contents (combinational) |
| ext_pin | input | 1 | External count input, asynchronous |
| irq | output | 1 | Sticky overflow flag |

## Verification
The assertions assume the port carries at most one access per cycle. They also assume the control register is not rewritten in the same edge as a wrap. Under those conditions a flag rise always coincides with a zero low byte. The bench keeps within these limits. It stops the counter before reconfiguring, and it issues exactly one strobe per cycle. It moves the external pin only at negative clock edges, with at least three cycles between changes, so every edge passes the synchronizer cleanly and is counted exactly once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned PS_SEL_W = 3;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_LOW  = 2'd1;
   localparam logic [1:0] ADDR_BUF  = 2'd2;
   localparam logic [1:0] ADDR_FLAG = 2'd3;

   typedef struct packed {
      logic                run;        // bit 7
      logic                narrow;     // bit 6: 8-bit width
      logic                ext_src;    // bit 5: count pin edges
      logic                fall_edge;  // bit 4: falling edge of pin
      logic                ps_bypass;  // bit 3: prescaler out of path
      logic [PS_SEL_W-1:0] ps_sel;     // bits 2:0
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic fall_sel,
   output logic edge_pulse
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= pin_in;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b0;
         else        sync_q[i] <= sync_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   always_comb begin
      if (fall_sel) edge_pulse = prev_q & ~sync_q[STAGES-1];
      else          edge_pulse = ~prev_q & sync_q[STAGES-1];
   end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic             bypass,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = 2 ** SEL_W;

   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W-1:0] pcnt_nxt;
   logic [PRE_W:0]   mask_wide;
   logic [PRE_W-1:0] mask;

   assign pcnt_nxt  = pcnt_q + PRE_W'(1);
   assign mask_wide = ((PRE_W+1)'(1) << ({1'b0, sel} + (SEL_W+1)'(1))) - (PRE_W+1)'(1);
   assign mask      = mask_wide[PRE_W-1:0];
   assign tick      = evt & ~clr & (bypass | ((pcnt_nxt & mask) == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pcnt_q <= '0;
      else if (clr)                pcnt_q <= '0;
      else if (evt && !bypass)     pcnt_q <= pcnt_nxt;
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [2*DATA_W-1:0] load_val,
   input  logic                inc,
   input  logic                narrow,
   output logic [2*DATA_W-1:0] cnt,
   output logic                wrap
);
   localparam int CNT_W = 2 * DATA_W;

   logic [DATA_W-1:0] lo_q, hi_q;
   logic              lo_full, all_full;

   assign cnt      = {hi_q, lo_q};
   assign lo_full  = &lo_q;
   assign all_full = &{hi_q, lo_q};
   assign wrap     = inc & ~load & (narrow ? lo_full : all_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (load) begin
         lo_q <= load_val[DATA_W-1:0];
         hi_q <= load_val[CNT_W-1:DATA_W];
      end else if (inc) begin
         lo_q <= lo_q + DATA_W'(1);
         if (!narrow && lo_full) hi_q <= hi_q + DATA_W'(1);
      end
   end
endmodule

// File: rtl/buffered_timer16.sv
module buffered_timer16
   import tmr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int INH_CYC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ext_pin,
   output logic              irq
);
   localparam int CNT_W = 2 * DATA_W;
   localparam int INH_W = $clog2(INH_CYC + 1);

   if (DATA_W != $bits(tmr_ctrl_t)) begin : g_bad_width
      $error("DATA_W must match the control register width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (INH_CYC < 1) begin : g_bad_inh
      $error("INH_CYC must be at least 1");
   end

   tmr_ctrl_t         ctrl_q;
   logic [DATA_W-1:0] hbuf_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              flag_q;
   logic [INH_W-1:0]  inh_q;

   logic wr_ctrl, wr_low, wr_buf, wr_flag, rd_low;
   logic edge_pulse, src_evt, evt, inc, wrap;

   assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
   assign wr_low  = wr_en && (addr == ADDR_LOW);
   assign wr_buf  = wr_en && (addr == ADDR_BUF);
   assign wr_flag = wr_en && (addr == ADDR_FLAG);
   assign rd_low  = rd_en && (addr == ADDR_LOW);

   tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (ext_pin),
      .fall_sel  (ctrl_q.fall_edge),
      .edge_pulse(edge_pulse)
   );

   assign src_evt = ctrl_q.ext_src ? edge_pulse : 1'b1;
   assign evt     = ctrl_q.run && (inh_q == '0) && !wr_low && src_evt;

   tmr_prescale #(.SEL_W(PS_SEL_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_low | wr_buf),
      .evt   (evt),
      .bypass(ctrl_q.ps_bypass),
      .sel   (ctrl_q.ps_sel),
      .tick  (inc)
   );

   tmr_count_core #(.DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_low),
      .load_val({hbuf_q, wdata}),
      .inc     (inc),
      .narrow  (ctrl_q.narrow),
      .cnt     (cnt_q),
      .wrap    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hbuf_q <= '0;
      else if (wr_buf) hbuf_q <= wdata;
      else if (rd_low) hbuf_q <= cnt_q[CNT_W-1:DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     inh_q <= '0;
      else if (wr_low)                inh_q <= INH_W'(INH_CYC);
      else if (inh_q != '0)           inh_q <= inh_q - INH_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (wrap)                  flag_q <= 1'b1;
      else if (wr_flag && !wdata[0])  flag_q <= 1'b0;
   end

   always_comb begin
      case (addr)
         ADDR_CTRL: rdata = ctrl_q;
         ADDR_LOW:  rdata = cnt_q[DATA_W-1:0];
         ADDR_BUF:  rdata = hbuf_q;
         default:   rdata = {{(DATA_W-1){1'b0}}, flag_q};
      endcase
   end

   assign irq = flag_q;
endmodule

// File: rtl/buffered_timer16_chk.sv
module buffered_timer16_chk #(
   parameter int DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          addr,
   input logic                wr_en,
   input logic                rd_en,
   input logic [DATA_W-1:0]   wdata,
   input logic [2*DATA_W-1:0] cnt,
   input logic [DATA_W-1:0]   hbuf,
   input logic                flag,
   input logic                narrow
);
   localparam int CNT_W = 2 * DATA_W;

   logic wr_low, wr_buf, flag_clr;
   assign wr_low   = wr_en && (addr == 2'd1);
   assign wr_buf   = wr_en && (addr == 2'd2);
   assign flag_clr = wr_en && (addr == 2'd3) && !wdata[0];

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_low |=> cnt == {$past(hbuf), $past(wdata)});

   assert_bufwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_buf |=> hbuf == $past(wdata));

   assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == 2'd1) |=> hbuf == $past(cnt[CNT_W-1:DATA_W]));

   assert_inh_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_low ##1 !wr_low |=> $stable(cnt));

   assert_inh_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_low ##1 !wr_low ##1 !wr_low |=> $stable(cnt));

   assert_narrow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && !wr_low) |=> $stable(cnt[CNT_W-1:DATA_W]));

   assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> cnt[DATA_W-1:0] == '0);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

bind buffered_timer16 buffered_timer16_chk #(.DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (addr),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .wdata (wdata),
   .cnt   (cnt_q),
   .hbuf  (hbuf_q),
   .flag  (flag_q),
   .narrow(ctrl_q.narrow)
);

// File: tb/buffered_timer16_bench.sv
module buffered_timer16_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       ext_pin = 1'b0;
   logic       irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   buffered_timer16 u_buffered_timer16 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .ext_pin(ext_pin), .irq(irq)
   );

   // ctrl, hi, lo, edges k after load, expected hi, lo, flag
   localparam int NV = 10;
   localparam logic [63:0] VEC [NV] = '{
      {8'h88, 8'h12, 8'h34, 16'd12,  8'h12, 8'h3E, 8'h00},
      {8'h88, 8'hFF, 8'hFE, 16'd5,   8'h00, 8'h01, 8'h01},
      {8'hC8, 8'h55, 8'hFD, 16'd6,   8'h55, 8'h01, 8'h01},
      {8'h80, 8'h00, 8'hFF, 16'd9,   8'h01, 8'h02, 8'h00},
      {8'h82, 8'h00, 8'h10, 16'd42,  8'h00, 8'h15, 8'h00},
      {8'h08, 8'hAB, 8'hCD, 16'd10,  8'hAB, 8'hCD, 8'h00},
      {8'h88, 8'h00, 8'hFF, 16'd3,   8'h01, 8'h00, 8'h00},
      {8'hC8, 8'h00, 8'hFF, 16'd3,   8'h00, 8'h00, 8'h01},
      {8'h87, 8'h00, 8'h00, 16'd602, 8'h00, 8'h02, 8'h00},
      {8'h88, 8'h40, 8'h00, 16'd2,   8'h40, 8'h00, 8'h00}
   };
   localparam string VREQ [NV] = '{"R2 R6", "R8", "R7", "R3", "R3",
                                   "R2", "R8", "R7", "R3", "R6"};

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end at a negative clock edge.
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      addr = a; #1 v = rdata;
   endtask

   task automatic pulse();
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, vf, vl, vh;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), v);
         check("R1 reg", {8'h0, v}, 16'h0);
      end
      check("R1 irq", {15'h0, irq}, 16'h0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, VEC[i][63:56] & 8'h7F);
         wr(2'd3, 8'h00);
         wr(2'd2, VEC[i][55:48]);
         wr(2'd1, VEC[i][47:40]);
         wr(2'd0, VEC[i][63:56]);
         repeat (int'(VEC[i][39:24]) - 1) @(negedge clk);
         peek(2'd3, vf);
         addr = 2'd1; rd_en = 1'b1; #1 vl = rdata;
         @(negedge clk);
         rd_en = 1'b0;
         peek(2'd2, vh);
         check({VREQ[i], " count"}, {vh, vl}, VEC[i][23:8]);
         check({VREQ[i], " flag"}, {8'h0, vf}, {8'h0, VEC[i][7:0]});
      end

      // R4 and R5: buffer write alone, low read latches high byte
      wr(2'd0, 8'h08);
      wr(2'd2, 8'h11);
      wr(2'd1, 8'h22);
      wr(2'd2, 8'h99);
      peek(2'd1, v);
      check("R4 low after buffer write", {8'h0, v}, 16'h0022);
      addr = 2'd1; rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      peek(2'd2, v);
      check("R5 buffer after low read", {8'h0, v}, 16'h0011);

      // R3: buffer write resets the prescaler (ratio 1:4)
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h81);
      repeat (4) @(negedge clk);
      wr(2'd2, 8'h00);
      peek(2'd1, v);
      check("R3 no tick on clear", {8'h0, v}, 16'h0000);
      repeat (3) @(negedge clk);
      peek(2'd1, v);
      check("R3 restart before ratio", {8'h0, v}, 16'h0000);
      @(negedge clk);
      peek(2'd1, v);
      check("R3 restart at ratio", {8'h0, v}, 16'h0001);

      // R9: sticky flag and clear rule
      wr(2'd0, 8'h48);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'hC8);
      repeat (2) @(negedge clk);
      wr(2'd0, 8'h48);
      repeat (5) @(negedge clk);
      peek(2'd3, v);
      check("R9 flag held", {8'h0, v}, 16'h0001);
      check("R9 irq held", {15'h0, irq}, 16'h0001);
      wr(2'd3, 8'h01);
      peek(2'd3, v);
      check("R9 write bit0=1 ignored", {8'h0, v}, 16'h0001);
      wr(2'd3, 8'h00);
      peek(2'd3, v);
      check("R9 cleared", {8'h0, v}, 16'h0000);
      check("R9 irq cleared", {15'h0, irq}, 16'h0000);

      // R11 and R10: external pin, rising edge
      wr(2'd0, 8'h28);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'hA8);
      repeat (4) @(negedge clk);
      peek(2'd1, v);
      check("R10 no count without pin edge", {8'h0, v}, 16'h0000);
      ext_pin = 1'b1;
      @(negedge clk); @(negedge clk);
      peek(2'd1, v);
      check("R11 not before third edge", {8'h0, v}, 16'h0000);
      @(negedge clk);
      peek(2'd1, v);
      check("R11 at third edge", {8'h0, v}, 16'h0001);
      ext_pin = 1'b0;
      repeat (6) @(negedge clk);
      peek(2'd1, v);
      check("R10 falling ignored in rising mode", {8'h0, v}, 16'h0001);
      for (int p = 0; p < 4; p++) pulse();
      repeat (4) @(negedge clk);
      peek(2'd1, v);
      check("R10 rising pulses", {8'h0, v}, 16'h0005);

      // R10: falling edge select
      wr(2'd0, 8'hB8);
      for (int p = 0; p < 3; p++) pulse();
      repeat (4) @(negedge clk);
      peek(2'd1, v);
      check("R10 falling pulses", {8'h0, v}, 16'h0008);
      ext_pin = 1'b1;
      repeat (5) @(negedge clk);
      peek(2'd1, v);
      check("R10 rising ignored in falling mode", {8'h0, v}, 16'h0008);
      ext_pin = 1'b0;
      repeat (5) @(negedge clk);
      peek(2'd1, v);
      check("R10 falling counted", {8'h0, v}, 16'h0009);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule